// File: doc/BRIEF.md
# Thermal Stall Throttle

This block lowers the dynamic power of a core by forcing stall cycles into the decode stage while the core runs hot. A 3-bit throttle level chooses how many cycles out of every repeating window of eight are stolen from issue. During a stolen cycle decode sends nothing forward, and a bubble with no work moves down the pipe where an instruction would have gone. The stall cycles are spread as evenly as possible across the window by an accumulator, so the pipe never sees a long run of back-to-back bubbles unless the level demands it.

The throttle level is sampled only on the last cycle of each window and applies from the first cycle of the next. A window therefore never mixes two levels. The over-temperature flag gates the stall output in the same cycle, so a cool core never stalls. A saturating counter reports how many stall cycles have been injected since reset.

Top module: `thermal_throttle`

## Requirements
- R1: During reset and in the first cycle after it, `stall_o` is 0 and `stall_count_o` is 0. The window phase starts at 0 on the first cycle after reset, and the active level starts at 0.
- R2: With an active level of 0, `stall_o` stays 0 in every cycle, even when `hot_i` is 1.
- R3: With `hot_i` held at 1 through a whole window and an active level of n, exactly n of that window's eight cycles have `stall_o` at 1.
- R4: With `hot_i` at 1, `stall_o` is 1 in the window phase p (0..7) exactly when floor((p+1)*n/8) > floor(p*n/8). For level 7, phase 0 is the only issue cycle.
- R5: `level_i` is sampled only in phase 7. The sampled value becomes the active level for the following window, so changes at any other phase have no effect on `stall_o`.
- R6: When `hot_i` is 0, `stall_o` is 0 in that same cycle, whatever the level.
- R7: `issue_valid_o` equals `inst_valid_i` AND NOT `stall_o` in the same cycle; a stall cycle issues a bubble.
- R8: Each cycle with `stall_o` at 1 raises `stall_count_o` by one. The new value is visible from the next cycle.
- R9: `stall_count_o` saturates at its all-ones value and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Over-temperature flag |
| level_i | input | WIN_LOG2 | Requested stall cycles per window |
| inst_valid_i | input | 1 | Decode has an instruction ready to issue |
| stall_o | output | 1 | Forced stall for this cycle |
| issue_valid_o | output | 1 | Instruction issued this cycle (0 = bubble) |
| stall_count_o | output | TALLY_W | Saturating count of injected stalls |

## Verification
The bench builds the block with the default window of eight and the even-spread variant. It also shrinks the stall tally to 6 bits, so a few windows at level 7 drive the counter into saturation within a short run. Levels 0, 3, 5 and 7 are used, together with level changes in the middle of a window, flag drops inside a window and an irregular instruction-valid pattern. Together these exercise every phase of the spreading rule and the window-boundary sampling.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // Variant of the stall placement inside a window
   typedef enum logic {
      SPREAD_EVEN  = 1'b0,  // accumulator spreading
      SPREAD_FRONT = 1'b1   // stalls grouped at the window head
   } spread_e;

   localparam int unsigned MAX_WIN_LOG2 = 8;

endpackage

// File: rtl/thr_phase.sv
module thr_phase #(
   parameter int unsigned WIN_LOG2 = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [WIN_LOG2-1:0] phase_o,
   output logic                last_o
);

   localparam logic [WIN_LOG2-1:0] LAST_PH = '1;

   logic [WIN_LOG2-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   assign phase_o = phase_q;
   assign last_o  = (phase_q == LAST_PH);

   // R4: the window wraps from the last phase back to phase 0
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (phase_o == '0));

endmodule

// File: rtl/thr_pattern.sv
module thr_pattern
   import thr_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 3,
   parameter spread_e     SPREAD   = SPREAD_EVEN
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WIN_LOG2-1:0] phase_i,
   input  logic                last_i,
   input  logic [WIN_LOG2-1:0] level_i,
   output logic                raw_o,
   output logic [WIN_LOG2-1:0] act_o
);

   localparam logic [WIN_LOG2-1:0] MAX_LVL = '1;

   // active level, reloaded on the last cycle of a window
   logic [WIN_LOG2-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      act_q <= '0;
      else if (last_i) act_q <= level_i;
   end

   assign act_o = act_q;

   generate
      if (SPREAD == SPREAD_EVEN) begin : g_even
         logic [WIN_LOG2-1:0] acc_q;
         logic [WIN_LOG2:0]   sum;

         assign sum   = {1'b0, acc_q} + {1'b0, act_q};
         assign raw_o = sum[WIN_LOG2];

         always_ff @(posedge clk) begin
            if (!rst_n)      acc_q <= '0;
            else if (last_i) acc_q <= '0;
            else             acc_q <= sum[WIN_LOG2-1:0];
         end
      end else begin : g_front
         assign raw_o = (phase_i < act_q);
      end
   endgenerate

   // checker bookkeeping: stalls seen so far in this window
   logic [WIN_LOG2:0] win_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      win_cnt_q <= '0;
      else if (last_i) win_cnt_q <= '0;
      else             win_cnt_q <= win_cnt_q + {{WIN_LOG2{1'b0}}, raw_o};
   end

   // R5: the active level only moves at a window boundary
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !last_i |=> $stable(act_o));

   // R2: level 0 never raises a stall request
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == '0) |-> !raw_o);

   // R3: a window closes with exactly the active level's stall count
   p_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
      last_i |-> (win_cnt_q + {{WIN_LOG2{1'b0}}, raw_o}) == {1'b0, act_o});

   // R4: the top level still leaves one issue cycle, at phase 0
   p_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == MAX_LVL && phase_i == '0 && SPREAD == SPREAD_EVEN) |-> !raw_o);

endmodule

// File: rtl/thr_tally.sv
module thr_tally #(
   parameter int unsigned TALLY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc_i,
   output logic [TALLY_W-1:0] count_o
);

   localparam logic [TALLY_W-1:0] TOP = '1;

   logic [TALLY_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;

   // R8: each stall cycle adds one below the ceiling
   p_incr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1));

   // R8: no stall, no change
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_i |=> $stable(count_o));

   // R9: once full, the tally stays full
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == TOP) |=> (count_o == TOP));

endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
   import thr_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 3,
   parameter int unsigned TALLY_W  = 16,
   parameter spread_e     SPREAD   = SPREAD_EVEN
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hot_i,
   input  logic [WIN_LOG2-1:0] level_i,
   input  logic                inst_valid_i,
   output logic                stall_o,
   output logic                issue_valid_o,
   output logic [TALLY_W-1:0]  stall_count_o
);

   // elaboration-time parameter checks
   if (WIN_LOG2 < 1 || WIN_LOG2 > MAX_WIN_LOG2) begin : g_bad_win
      $error("thermal_throttle: WIN_LOG2 out of range");
   end
   if (TALLY_W < 1) begin : g_bad_tally
      $error("thermal_throttle: TALLY_W must be positive");
   end

   logic [WIN_LOG2-1:0] phase;
   logic                last;
   logic                raw;
   logic [WIN_LOG2-1:0] act;

   thr_phase #(.WIN_LOG2(WIN_LOG2)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase),
      .last_o  (last)
   );

   thr_pattern #(.WIN_LOG2(WIN_LOG2), .SPREAD(SPREAD)) u_pattern (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_i (phase),
      .last_i  (last),
      .level_i (level_i),
      .raw_o   (raw),
      .act_o   (act)
   );

   assign stall_o       = hot_i & raw;
   assign issue_valid_o = inst_valid_i & ~stall_o;

   thr_tally #(.TALLY_W(TALLY_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (stall_o),
      .count_o (stall_count_o)
   );

   // R1: the first cycle after reset is phase 0 with level 0, so no stall
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (rst_n -> (!stall_o && stall_count_o == '0)));

endmodule

// File: tb/thermal_throttle_bench.sv
module thermal_throttle_bench;

   localparam int W      = 3;
   localparam int WIN    = 1 << W;
   localparam int TW     = 6;
   localparam int TMAX   = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hot;
   logic [W-1:0]  lvl;
   logic          vld;
   logic          stall;
   logic          issue;
   logic [TW-1:0] cnt;

   always #2.5 clk = ~clk;   // 200 MHz

   thermal_throttle #(.WIN_LOG2(W), .TALLY_W(TW)) u_thermal_throttle (
      .clk           (clk),
      .rst_n         (rst_n),
      .hot_i         (hot),
      .level_i       (lvl),
      .inst_valid_i  (vld),
      .stall_o       (stall),
      .issue_valid_o (issue),
      .stall_count_o (cnt)
   );

   typedef struct {
      logic  e_stall;
      logic  e_issue;
      int    e_cnt;
      string tag;
   } item_t;

   item_t q[$];
   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // bench model state
   int m_phase = 0;
   int m_act   = 0;
   int m_cnt   = 0;
   int cyc     = 0;

   function automatic bit pat(int n, int p);
      return (((p + 1) * n) / WIN) > ((p * n) / WIN);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: called just after a rising edge
   task automatic step(bit h, int l, bit v, string tag);
      item_t it;
      hot = h; lvl = l[W-1:0]; vld = v;
      it.e_stall = h && pat(m_act, m_phase);
      it.e_issue = v && !it.e_stall;
      it.e_cnt   = m_cnt;
      it.tag     = tag;
      q.push_back(it);
      if (it.e_stall && m_cnt < TMAX) m_cnt++;
      if (m_phase == WIN - 1) m_act = l;
      m_phase = (m_phase + 1) % WIN;
      cyc++;
      @(posedge clk); #1;
   endtask

   task automatic window(bit h, int l, string tag);
      for (int i = 0; i < WIN; i++) step(h, l, 1'b1, tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, int'(stall), int'(it.e_stall));
            check("R7", int'(issue), int'(it.e_issue));
            check(it.e_cnt == TMAX ? "R9" : "R8", int'(cnt), it.e_cnt);
         end
      end
   end

   // watchdog
   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; hot = 1'b1; lvl = 3'd7; vld = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", int'(stall), 0);
      check("R1", int'(cnt), 0);
      rst_n = 1'b1;
      // R5: first window runs at level 0 although 5 is requested
      window(1'b1, 5, "R5");
      // R4: level 5 spread
      window(1'b1, 5, "R4");
      // R2: level 0 (requested in prior window, active from next)
      window(1'b1, 0, "R4");
      window(1'b1, 0, "R2");
      // R3: level 3
      window(1'b1, 3, "R2");
      window(1'b1, 3, "R3");
      // R5: level wiggles mid-window, only phase 7 value counts
      for (int i = 0; i < WIN; i++) step(1'b1, (i == WIN - 1) ? 1 : 6, 1'b1, "R5");
      for (int i = 0; i < WIN; i++) step(1'b1, (i == 3) ? 7 : 4, 1'b1, "R5");
      // R6: flag drops inside windows
      for (int i = 0; i < 2 * WIN; i++) step(i[1], 7, 1'b1, "R6");
      window(1'b0, 7, "R6");
      // R7: irregular instruction supply
      for (int i = 0; i < 2 * WIN; i++) step(1'b1, 5, (cyc % 3) != 1, "R7");
      // R4 and R9: level 7 until the tally saturates
      for (int k = 0; k < 12; k++) window(1'b1, 7, "R4");
      repeat (2) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule